// File: doc/BRIEF.md
# Processor-to-Coprocessor Mailbox Unit

The block carries 32-bit messages between a control processor and a coprocessor. The control processor sees a small register window (write strobe, read strobe, two-bit address). The coprocessor uses a channel port: it raises a request, names a channel, and the transfer completes in the cycle in which the block answers with an acknowledge. When the acknowledge stays low, the coprocessor waits.

Messages travel through three queues:
- Two single-entry outbound queues run from the coprocessor to the control processor. One of them raises an interrupt whenever it is written.
- A four-entry inbound queue runs the other way.

A full outbound queue makes the coprocessor wait. A full inbound queue does not make the control processor wait: the newest entry is replaced. A status word reports the occupancy of each outbound queue and the free inbound slots.

Top module: `mbox_unit`

## Requirements
- R1: After reset, both outbound queues are empty, all four inbound slots are free and `cp_irq` is low. The status word (read at address 3) is therefore 32'h0004_0000.
- R2: The status word carries these fields: bit 0 = plain outbound entry present, bit 8 = interrupting outbound entry present, bits 18:16 = inbound free slots, bit 24 = interrupt pending. All other bits read 0.
- R3: A coprocessor write on channel 0 (plain outbound) or channel 1 (interrupting outbound) is acknowledged in the same cycle when that queue is empty. Its data is readable at control address 1 (channel 0) or address 2 (channel 1) from the next cycle.
- R4: A coprocessor write to a full outbound queue gets no acknowledge. The write is accepted in the cycle after the control processor reads that queue.
- R5: A control read strobe at address 1 or 2 returns the entry and empties that queue. If the queue is empty, the read returns 0.
- R6: An accepted write on channel 1 sets `cp_irq` from the next cycle.
- R7: `cp_irq` clears after a control read at address 2, or after a control write at address 3 with data bit 0 set. A write at address 3 with bit 0 clear leaves `cp_irq` unchanged. A new interrupt in the same cycle takes precedence over a clear.
- R8: Control writes at address 0 fill the inbound queue. Coprocessor reads on channel 2 (with `co_we` low) return the entries oldest first.
- R9: A control write to a full inbound queue replaces the most recently written entry. The older three entries keep their order and the free-slot count stays 0.
- R10: A coprocessor read of an empty inbound queue gets no acknowledge until data is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| cp_we | input | 1 | Control processor write strobe |
| cp_re | input | 1 | Control processor read strobe (pops at addresses 1 and 2) |
| cp_addr | input | 2 | 0 inbound data, 1 outbound data, 2 interrupting outbound data, 3 status/clear |
| cp_wdata | input | 32 | Control processor write data |
| cp_rdata | output | 32 | Control processor read data, combinational from `cp_addr` |
| cp_irq | output | 1 | Interrupt to the control processor |
| co_req | input | 1 | Coprocessor channel request |
| co_we | input | 1 | 1 = write (channels 0 and 1), 0 = read (channel 2) |
| co_chan | input | 2 | Channel number |
| co_wdata | input | 32 | Coprocessor write data |
| co_rdata | output | 32 | Oldest inbound entry, valid with `co_ack` on a read |
| co_ack | output | 1 | Transfer completes at the next rising edge |

## Verification
Two kinds of result are due at different times:
- `co_ack`, `co_rdata` and `cp_rdata` are combinational. The bench samples them one time unit after it drives a request, before the edge that commits the transfer.
- Queue state, the status word and `cp_irq` change at that edge. The bench samples them only at the following falling edge, one cycle after the stimulus.

Stall checks hold a refused request across an edge and then confirm that the queue content is unchanged. Overwrite checks drain the inbound queue to show which entry was replaced.

// File: rtl/mbox_unit.sv
module mbox_unit #(
  parameter int DW       = 32,
  parameter int IN_DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cp_we,
  input  logic          cp_re,
  input  logic [1:0]    cp_addr,
  input  logic [DW-1:0] cp_wdata,
  output logic [DW-1:0] cp_rdata,
  output logic          cp_irq,
  input  logic          co_req,
  input  logic          co_we,
  input  logic [1:0]    co_chan,
  input  logic [DW-1:0] co_wdata,
  output logic [DW-1:0] co_rdata,
  output logic          co_ack
);
  localparam int PW = $clog2(IN_DEPTH);
  localparam int CW = $clog2(IN_DEPTH + 1);

  logic          ob_v, oi_v;
  logic [DW-1:0] ob_d, oi_d;
  logic [DW-1:0] mem [IN_DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic [DW-1:0] status;

  assign co_ack = co_req && (co_we ? ((co_chan == 2'd0 && !ob_v) || (co_chan == 2'd1 && !oi_v))
                                   : (co_chan == 2'd2 && cnt != '0));

  wire ob_wr   = co_ack && co_we && co_chan == 2'd0;
  wire oi_wr   = co_ack && co_we && co_chan == 2'd1;
  wire in_pop  = co_ack && !co_we;
  wire ob_rd   = cp_re && cp_addr == 2'd1;
  wire oi_rd   = cp_re && cp_addr == 2'd2;
  wire in_push = cp_we && cp_addr == 2'd0;
  wire irq_clr = oi_rd || (cp_we && cp_addr == 2'd3 && cp_wdata[0]);
  wire in_full = cnt == CW'(IN_DEPTH);
  wire in_ovw  = in_push && in_full && !in_pop;
  wire in_new  = in_push && !in_ovw;

  assign co_rdata = mem[rp];

  always_comb begin
    status = '0;
    status[0] = ob_v;
    status[8] = oi_v;
    status[16 +: CW] = CW'(IN_DEPTH) - cnt;
    status[24] = cp_irq;
  end

  always_comb begin
    case (cp_addr)
      2'd1:    cp_rdata = ob_v ? ob_d : '0;
      2'd2:    cp_rdata = oi_v ? oi_d : '0;
      2'd3:    cp_rdata = status;
      default: cp_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ob_v   <= 1'b0;
      oi_v   <= 1'b0;
      cp_irq <= 1'b0;
    end else begin
      if (ob_wr) ob_v <= 1'b1;
      else if (ob_rd) ob_v <= 1'b0;
      if (oi_wr) oi_v <= 1'b1;
      else if (oi_rd) oi_v <= 1'b0;
      if (oi_wr) cp_irq <= 1'b1;
      else if (irq_clr) cp_irq <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (ob_wr) ob_d <= co_wdata;
    if (oi_wr) oi_d <= co_wdata;
    if (in_ovw) mem[PW'(wp - 1'b1)] <= cp_wdata;
    else if (in_new) mem[wp] <= cp_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (in_new) wp <= wp + 1'b1;
      if (in_pop) rp <= rp + 1'b1;
      cnt <= cnt + CW'(in_new) - CW'(in_pop);
    end
  end
endmodule

// File: rtl/mbox_unit_chk.sv
module mbox_unit_chk #(
  parameter int CW = 3,
  parameter int IN_DEPTH = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cp_we,
  input logic          cp_re,
  input logic [1:0]    cp_addr,
  input logic          cp_irq,
  input logic          co_req,
  input logic          co_we,
  input logic [1:0]    co_chan,
  input logic          co_ack,
  input logic          ob_v,
  input logic          oi_v,
  input logic [CW-1:0] cnt
);
  assert_full_out_stalls_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (co_req && co_we && ((co_chan == 2'd0 && ob_v) || (co_chan == 2'd1 && oi_v))) |-> !co_ack);

  assert_irq_raised_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (co_ack && co_we && co_chan == 2'd1) |=> cp_irq);

  assert_irq_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_re && cp_addr == 2'd2 && !(co_ack && co_we && co_chan == 2'd1)) |=> !cp_irq);

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(IN_DEPTH));

  assert_overwrite_keeps_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_we && cp_addr == 2'd0 && cnt == CW'(IN_DEPTH) && !(co_ack && !co_we)) |=> cnt == CW'(IN_DEPTH));

  assert_empty_read_stalls_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (co_req && !co_we && cnt == '0) |-> !co_ack);
endmodule

bind mbox_unit mbox_unit_chk #(.CW(CW), .IN_DEPTH(IN_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cp_we(cp_we), .cp_re(cp_re), .cp_addr(cp_addr),
  .cp_irq(cp_irq), .co_req(co_req), .co_we(co_we), .co_chan(co_chan),
  .co_ack(co_ack), .ob_v(ob_v), .oi_v(oi_v), .cnt(cnt)
);

// File: tb/test_mbox_unit.sv
module test_mbox_unit;
  logic clk = 0, rst_n = 0;
  logic cp_we = 0, cp_re = 0, co_req = 0, co_we = 0;
  logic [1:0] cp_addr = 0, co_chan = 0;
  logic [31:0] cp_wdata = 0, co_wdata = 0, cp_rdata, co_rdata;
  logic cp_irq, co_ack;
  int nvec = 0, nerr = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mbox_unit i_mbox_unit (.*);

  localparam logic [35:0] VEC [5] = '{
    {32'hA000_0001, 4'd3}, {32'hB000_0002, 4'd2}, {32'hC000_0003, 4'd1},
    {32'hD000_0004, 4'd0}, {32'hE000_0005, 4'd0}};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cp_write(logic [1:0] a, logic [31:0] d);
    @(negedge clk); cp_addr = a; cp_wdata = d; cp_we = 1;
    @(negedge clk); cp_we = 0;
  endtask

  task automatic cp_pop(logic [1:0] a, output logic [31:0] d);
    @(negedge clk); cp_addr = a; cp_re = 1; #1 d = cp_rdata;
    @(negedge clk); cp_re = 0;
  endtask

  task automatic look(logic [1:0] a, output logic [31:0] d);
    @(negedge clk); cp_addr = a; #1 d = cp_rdata;
  endtask

  task automatic co_op(logic we, logic [1:0] ch, logic [31:0] wd,
                       output logic ack, output logic [31:0] rd);
    @(negedge clk); co_req = 1; co_we = we; co_chan = ch; co_wdata = wd;
    #1 ack = co_ack; rd = co_rdata;
    @(negedge clk); co_req = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, r;
    logic a;
    repeat (3) @(negedge clk);
    rst_n = 1;
    look(2'd3, d); chk("R1 status after reset", d, 32'h0004_0000);
    chk("R1 irq after reset", {31'd0, cp_irq}, 32'd0);

    foreach (VEC[i]) begin
      cp_write(2'd0, VEC[i][35:4]);
      look(2'd3, d); chk("R2 inbound free slots", d, {13'd0, VEC[i][2:0], 16'd0});
    end

    co_op(0, 2'd2, 0, a, r); chk("R8 ack", {31'd0, a}, 1); chk("R8 first", r, 32'hA000_0001);
    co_op(0, 2'd2, 0, a, r); chk("R8 second", r, 32'hB000_0002);
    co_op(0, 2'd2, 0, a, r); chk("R8 third", r, 32'hC000_0003);
    co_op(0, 2'd2, 0, a, r); chk("R9 newest replaced", r, 32'hE000_0005);
    co_op(0, 2'd2, 0, a, r); chk("R10 empty read stalls", {31'd0, a}, 0);
    look(2'd3, d); chk("R10 still empty", d, 32'h0004_0000);

    co_op(1, 2'd0, 32'h1111_1111, a, r); chk("R3 ack when empty", {31'd0, a}, 1);
    look(2'd3, d); chk("R2 outbound bit", d, 32'h0004_0001);
    look(2'd1, d); chk("R3 data visible", d, 32'h1111_1111);
    co_op(1, 2'd0, 32'h3333_3333, a, r); chk("R4 full stalls", {31'd0, a}, 0);
    cp_pop(2'd1, d); chk("R4 original kept", d, 32'h1111_1111);
    look(2'd1, d); chk("R5 empty reads zero", d, 0);
    co_op(1, 2'd0, 32'h3333_3333, a, r); chk("R4 accepted after read", {31'd0, a}, 1);
    cp_pop(2'd1, d); chk("R5 pop data", d, 32'h3333_3333);
    look(2'd3, d); chk("R5 emptied", d, 32'h0004_0000);

    co_op(1, 2'd1, 32'h4444_4444, a, r);
    chk("R6 irq set", {31'd0, cp_irq}, 1);
    look(2'd3, d); chk("R2 int bits", d, 32'h0104_0100);
    co_op(1, 2'd1, 32'h5555_5555, a, r); chk("R4 int queue full stalls", {31'd0, a}, 0);
    cp_write(2'd3, 32'h0000_0000); chk("R7 clear bit low keeps irq", {31'd0, cp_irq}, 1);
    cp_pop(2'd2, d); chk("R3 int data", d, 32'h4444_4444);
    chk("R7 read clears irq", {31'd0, cp_irq}, 0);
    co_op(1, 2'd1, 32'h6666_6666, a, r); chk("R6 irq again", {31'd0, cp_irq}, 1);
    cp_write(2'd3, 32'h0000_0001); chk("R7 clear write", {31'd0, cp_irq}, 0);
    look(2'd3, d); chk("R7 entry stays after clear", d, 32'h0004_0100);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule